// File: doc/BRIEF.md
# Two-Level Page Walker with Translation Buffer

This block maps a 32-bit linear address to a physical address using two-level paging with 4 KB pages. The address is split into three fields: the top 10 bits pick a directory entry, the next 10 bits pick a page-table entry, and the low 12 bits are the byte offset, which passes through unchanged. On a miss the block does the walk itself. It reads the directory entry, then the table entry, through a single memory read port that has one read outstanding at a time. It checks the present and permission flags along the way.

An eight-slot, fully associative translation buffer keeps translations that have been resolved. A repeated access to a cached page is answered in the cycle the request is presented, with no memory traffic. Slots are replaced in round-robin order. Writing the directory base register clears every slot. If that write lands while a walk is in flight, the walk still answers but leaves nothing in the buffer.

A requester presents a request while `req_ready` is high and holds it for that one cycle only. The result arrives on `rsp_valid`: in the same cycle on a hit, or after the walk on a miss.

Top module: `pgwalk_xlat`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` and `mem_rd_valid` are 0, and the buffer holds no translation, so the first access to any page walks.
- R2: The first walk read goes to address {base[31:12], vaddr[31:22], 2'b00}, which is the directory base with its low 12 bits cleared plus four times the directory index.
- R3: The second walk read goes to {pde[31:12], vaddr[21:12], 2'b00}, where pde is the directory entry just read.
- R4: A successful translation returns {pte[31:12], vaddr[11:0]}, where pte is the table entry. A walk answers with `rsp_valid` two cycles after the cycle in which the table data returns.
- R5: Entry bit 0 is the present flag. If it is clear in the directory entry, the walk ends with a fault after one read. If it is clear in the table entry, the walk ends with a fault after two reads. A faulting response carries `rsp_paddr` = 0.
- R6: Entry bit 1 allows writes and entry bit 2 allows user access. A write faults unless bit 1 is set at both levels. A user access faults unless bit 2 is set at both levels. Reads ignore bit 1, and supervisor accesses ignore bit 2.
- R7: A request whose page is cached is answered in the same cycle it is presented, with the offset passed through and no memory read.
- R8: The buffer has 8 slots, filled in round-robin order starting from slot 0 after reset or a flush. The ninth distinct page evicts the oldest one.
- R9: Writing the base register clears every buffer slot, and later walks use the new base. `req_ready` is 0 in any cycle in which the base register is written.
- R10: A walk during which the base register is written still returns its result, but the result is not cached.
- R11: Each memory read is a one-cycle `mem_rd_valid` pulse. No new read is issued until the previous one has returned on `mem_rd_done`. A miss issues exactly one read per level it reaches.
- R12: A walk that ends on a clear present flag is not cached, so repeating it walks again. A walk that passes both present checks is cached even if its permission check faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_we | input | 1 | Write strobe for the directory base register |
| base_wdata | input | 32 | New directory base (bits 31:12 are kept) |
| req_valid | input | 1 | Translation request present |
| req_vaddr | input | 32 | Linear address to translate |
| req_write | input | 1 | Request is a write |
| req_user | input | 1 | Request is made at user privilege |
| req_ready | output | 1 | A request is taken this cycle |
| rsp_valid | output | 1 | Result present |
| rsp_paddr | output | 32 | Physical address, 0 on fault |
| rsp_fault | output | 1 | Translation failed a present or permission check |
| mem_rd_valid | output | 1 | One-cycle read request to memory |
| mem_rd_addr | output | 32 | Entry address to read |
| mem_rd_done | input | 1 | Read data returned |
| mem_rd_data | input | 32 | Entry value returned |

## Verification
Translations are driven as cold misses, repeats of the same page with different offsets, and accesses that reach a page with a missing directory entry or a missing table entry. The number of memory reads and the entry addresses show whether a walk occurred and which level stopped it. Read-only pages, supervisor pages and a read-only directory entry are each probed with read, write, user and supervisor accesses. These cases separate the per-level flag combination and show that permission faults still fill the buffer while present faults do not. A run of nine distinct pages followed by interleaved revisits exposes the round-robin victim order. Base writes are made both between walks and in the middle of a walk, which separates a plain flush, the use of the new base, and the suppressed fill.

// File: rtl/pgwalk_xlat.sv
module pgwalk_xlat #(
  parameter int SLOTS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        base_we,
  input  logic [31:0] base_wdata,
  input  logic        req_valid,
  input  logic [31:0] req_vaddr,
  input  logic        req_write,
  input  logic        req_user,
  output logic        req_ready,
  output logic        rsp_valid,
  output logic [31:0] rsp_paddr,
  output logic        rsp_fault,
  output logic        mem_rd_valid,
  output logic [31:0] mem_rd_addr,
  input  logic        mem_rd_done,
  input  logic [31:0] mem_rd_data
);
  localparam int PW = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  typedef enum logic [2:0] {S_IDLE, S_DIR, S_TBL, S_FILL, S_RESP} st_t;

  st_t           st_q;
  logic [19:0]   base_q;
  logic [SLOTS-1:0] v_q;
  logic [19:0]   vpn_q [SLOTS];
  logic [19:0]   pfn_q [SLOTS];
  logic          rw_q  [SLOTS];
  logic          us_q  [SLOTS];
  logic [PW-1:0] ptr_q;

  logic [19:0] wvpn_q, frame_q;
  logic [11:0] off_q;
  logic        wr_q, usr_q, pde_rw_q, pde_us_q, ew_q, eu_q, drop_q;
  logic        fault_q, rd_v_q;
  logic [31:0] pa_q, rd_a_q;

  logic        hit, hit_rw, hit_us, hit_deny;
  logic [19:0] hit_pfn;
  logic        unused_bits;

  function automatic logic deny(input logic rw, input logic us,
                                input logic wr, input logic usr);
    return (wr & ~rw) | (usr & ~us);
  endfunction

  always_comb begin
    hit     = 1'b0;
    hit_pfn = '0;
    hit_rw  = 1'b0;
    hit_us  = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      if (v_q[i] && vpn_q[i] == req_vaddr[31:12]) begin
        hit     = 1'b1;
        hit_pfn = pfn_q[i];
        hit_rw  = rw_q[i];
        hit_us  = us_q[i];
      end
    end
  end

  assign hit_deny     = deny(hit_rw, hit_us, req_write, req_user);
  assign req_ready    = (st_q == S_IDLE) && !base_we;
  assign rsp_valid    = (st_q == S_RESP) || (req_valid && req_ready && hit);
  assign rsp_fault    = (st_q == S_RESP) ? fault_q : hit_deny;
  assign rsp_paddr    = (st_q == S_RESP) ? pa_q :
                        (hit_deny ? 32'h0 : {hit_pfn, req_vaddr[11:0]});
  assign mem_rd_valid = rd_v_q;
  assign mem_rd_addr  = rd_a_q;
  assign unused_bits  = ^{mem_rd_data[11:3], base_wdata[11:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      base_q   <= '0;
      v_q      <= '0;
      ptr_q    <= '0;
      rd_v_q   <= 1'b0;
      rd_a_q   <= '0;
      drop_q   <= 1'b0;
      fault_q  <= 1'b0;
      pa_q     <= '0;
      wvpn_q   <= '0;
      off_q    <= '0;
      wr_q     <= 1'b0;
      usr_q    <= 1'b0;
      pde_rw_q <= 1'b0;
      pde_us_q <= 1'b0;
      ew_q     <= 1'b0;
      eu_q     <= 1'b0;
      frame_q  <= '0;
    end else begin
      rd_v_q <= 1'b0;
      case (st_q)
        S_IDLE: begin
          drop_q <= 1'b0;
          if (req_valid && req_ready && !hit) begin
            wvpn_q <= req_vaddr[31:12];
            off_q  <= req_vaddr[11:0];
            wr_q   <= req_write;
            usr_q  <= req_user;
            rd_v_q <= 1'b1;
            rd_a_q <= {base_q, req_vaddr[31:22], 2'b00};
            st_q   <= S_DIR;
          end
        end
        S_DIR: begin
          if (mem_rd_done) begin
            if (!mem_rd_data[0]) begin
              fault_q <= 1'b1;
              pa_q    <= '0;
              st_q    <= S_RESP;
            end else begin
              pde_rw_q <= mem_rd_data[1];
              pde_us_q <= mem_rd_data[2];
              rd_v_q   <= 1'b1;
              rd_a_q   <= {mem_rd_data[31:12], wvpn_q[9:0], 2'b00};
              st_q     <= S_TBL;
            end
          end
        end
        S_TBL: begin
          if (mem_rd_done) begin
            if (!mem_rd_data[0]) begin
              fault_q <= 1'b1;
              pa_q    <= '0;
              st_q    <= S_RESP;
            end else begin
              frame_q <= mem_rd_data[31:12];
              ew_q    <= pde_rw_q & mem_rd_data[1];
              eu_q    <= pde_us_q & mem_rd_data[2];
              st_q    <= S_FILL;
            end
          end
        end
        S_FILL: begin
          if (!drop_q) begin
            v_q[ptr_q]   <= 1'b1;
            vpn_q[ptr_q] <= wvpn_q;
            pfn_q[ptr_q] <= frame_q;
            rw_q[ptr_q]  <= ew_q;
            us_q[ptr_q]  <= eu_q;
            ptr_q        <= (ptr_q == PW'(SLOTS - 1)) ? '0 : ptr_q + 1'b1;
          end
          fault_q <= deny(ew_q, eu_q, wr_q, usr_q);
          pa_q    <= deny(ew_q, eu_q, wr_q, usr_q) ? 32'h0 : {frame_q, off_q};
          st_q    <= S_RESP;
        end
        default: st_q <= S_IDLE;
      endcase
      if (base_we) begin
        base_q <= base_wdata[31:12];
        v_q    <= '0;
        ptr_q  <= '0;
        if (st_q != S_IDLE) drop_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pgwalk_xlat_chk.sv
module pgwalk_xlat_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        base_we,
  input logic        req_valid,
  input logic [31:0] req_vaddr,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic [31:0] rsp_paddr,
  input logic        rsp_fault,
  input logic        mem_rd_valid
);
  a_r11_read_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |=> !mem_rd_valid);

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_rd_valid);

  a_r9_base_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    base_we |-> !req_ready);

  a_r5_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> rsp_paddr == 32'h0);

  a_r7_hit_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && rsp_valid && !rsp_fault) |->
      rsp_paddr[11:0] == req_vaddr[11:0]);

  a_r7_hit_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && rsp_valid) |=> !mem_rd_valid);
endmodule

bind pgwalk_xlat pgwalk_xlat_chk u_chk (.*);

// File: tb/tb_pgwalk_xlat.sv
module tb_pgwalk_xlat;
  localparam int LAT = 2;
  localparam logic [2:0] FALL = 3'b111;

  logic clk = 1'b0, rst_n = 1'b0;
  logic base_we = 1'b0;
  logic [31:0] base_wdata = '0;
  logic req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic req_ready, rsp_valid, rsp_fault, mem_rd_valid;
  logic [31:0] rsp_paddr, mem_rd_addr;
  logic mem_rd_done = 1'b0;
  logic [31:0] mem_rd_data = '0;

  always #4 clk = ~clk;

  pgwalk_xlat dut (
    .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_wdata(base_wdata),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_write(req_write),
    .req_user(req_user), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .mem_rd_valid(mem_rd_valid),
    .mem_rd_addr(mem_rd_addr), .mem_rd_done(mem_rd_done), .mem_rd_data(mem_rd_data)
  );

  int checks = 0, errors = 0, got = 0, rd_count = 0;
  logic [31:0] mem [logic [31:0]];
  logic [31:0] rd_log [$];
  logic [31:0] epa_q [$];
  bit          ef_q [$];
  string       tag_q [$];
  logic [31:0] cur_base = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  function automatic logic [31:0] dir_a(input logic [31:0] b, input logic [31:0] va);
    return {b[31:12], va[31:22], 2'b00};
  endfunction
  function automatic logic [31:0] tbl_a(input logic [31:0] pt, input logic [31:0] va);
    return {pt[31:12], va[21:12], 2'b00};
  endfunction

  task automatic map(input logic [31:0] b, input logic [31:0] va, input logic [31:0] pt,
                     input logic [2:0] pfl, input logic [19:0] fr, input logic [2:0] tfl);
    mem[dir_a(b, va)] = {pt[31:12], 9'h0, pfl};
    mem[tbl_a(pt, va)] = {fr, 9'h0, tfl};
  endtask

  // memory model: one read at a time, LAT cycles of latency
  initial forever begin
    @(negedge clk);
    if (mem_rd_valid) begin
      automatic logic [31:0] a = mem_rd_addr;
      rd_count++;
      rd_log.push_back(a);
      repeat (LAT) @(posedge clk);
      #2;
      mem_rd_done = 1'b1;
      mem_rd_data = mem.exists(a) ? mem[a] : 32'h0;
      @(posedge clk);
      #2 mem_rd_done = 1'b0;
    end
  end

  // monitor: compare responses against the scoreboard
  initial forever begin
    @(negedge clk);
    if (rsp_valid) begin
      if (epa_q.size() == 0) begin
        chk(1'b0, "R4", "unexpected response", rsp_paddr, 32'h0);
      end else begin
        automatic logic [31:0] ep = epa_q.pop_front();
        automatic bit ef = ef_q.pop_front();
        automatic string tg = tag_q.pop_front();
        chk(rsp_paddr == ep, tg, "paddr", rsp_paddr, ep);
        chk(rsp_fault == ef, tg, "fault", {31'h0, rsp_fault}, {31'h0, ef});
      end
      got++;
    end
  end

  task automatic wbase(input logic [31:0] b);
    @(posedge clk);
    #2 base_we = 1'b1; base_wdata = b;
    @(negedge clk);
    chk(req_ready == 1'b0, "R9", "ready during base write", {31'h0, req_ready}, 32'h0);
    @(posedge clk);
    #2 base_we = 1'b0;
    cur_base = b;
  endtask

  task automatic xw(input logic [31:0] va, input bit wr, input bit us,
                    input logic [31:0] pt, input logic [31:0] epa, input bit ef,
                    input int nrd, input string tg);
    int r0, g0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #2;
    r0 = rd_count; g0 = got; rd_log.delete();
    req_valid = 1'b1; req_vaddr = va; req_write = wr; req_user = us;
    epa_q.push_back(epa); ef_q.push_back(ef); tag_q.push_back(tg);
    @(negedge clk);
    if (nrd == 0)
      chk(rsp_valid == 1'b1, "R7", "same-cycle hit", {31'h0, rsp_valid}, 32'h1);
    @(posedge clk);
    #2 req_valid = 1'b0;
    while (got == g0) @(negedge clk);
    chk(rd_count - r0 == nrd, "R11", {"read count ", tg}, rd_count - r0, nrd);
    if (nrd >= 1 && rd_log.size() >= 1)
      chk(rd_log[0] == dir_a(cur_base, va), "R2", "directory read addr", rd_log[0], dir_a(cur_base, va));
    if (nrd == 2 && rd_log.size() >= 2)
      chk(rd_log[1] == tbl_a(pt, va), "R3", "table read addr", rd_log[1], tbl_a(pt, va));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "R4", "watchdog expired", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    logic [31:0] B1, B2, pt1, vaA, vaD, vaE, vaR, vaS, vaW, vaQ;
    B1 = 32'h0001_0000; B2 = 32'h0003_0000; pt1 = 32'h0002_1000;
    vaA = {10'd1, 10'd2, 12'h345};
    vaD = {10'd5, 10'd0, 12'h010};
    vaE = {10'd6, 10'd7, 12'h020};
    vaR = {10'd8, 10'd1, 12'h030};
    vaS = {10'd9, 10'd3, 12'h040};
    vaW = {10'd10, 10'd4, 12'h050};
    vaQ = {10'd40, 10'd9, 12'h777};
    map(B1, vaA, pt1, FALL, 20'hABCDE, FALL);
    mem[tbl_a(32'h0002_6000, vaE) - 32'h0] = 32'h0;
    mem[dir_a(B1, vaE)] = {20'h00026, 9'h0, FALL};
    map(B1, vaR, 32'h0002_8000, FALL, 20'h11111, 3'b101);
    map(B1, vaS, 32'h0002_9000, FALL, 20'h22222, 3'b011);
    map(B1, vaW, 32'h0002_A000, 3'b101, 20'h33333, FALL);
    map(B2, vaA, 32'h0004_0000, FALL, 20'h55555, FALL);
    for (int i = 0; i < 9; i++)
      map(B2, {10'(20 + i), 10'(i), 12'h0}, 32'h0006_0000 + i * 32'h1000, FALL, 20'h70000 + 20'(i), FALL);
    map(B2, vaQ, 32'h0008_0000, FALL, 20'h99999, FALL);

    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready after reset", {31'h0, req_ready}, 32'h1);
    chk(rsp_valid == 1'b0, "R1", "no response after reset", {31'h0, rsp_valid}, 32'h0);
    chk(mem_rd_valid == 1'b0, "R1", "no read after reset", {31'h0, mem_rd_valid}, 32'h0);
    wbase(B1);

    xw(vaA, 0, 1, pt1, 32'hABCD_E345, 0, 2, "R1");
    xw(vaA, 0, 1, pt1, 32'hABCD_E345, 0, 0, "R7");
    xw({vaA[31:12], 12'hFFF}, 1, 1, pt1, 32'hABCD_EFFF, 0, 0, "R4");

    xw(vaD, 0, 0, 0, 32'h0, 1, 1, "R5");
    xw(vaD, 0, 0, 0, 32'h0, 1, 1, "R12");
    xw(vaE, 0, 0, 32'h0002_6000, 32'h0, 1, 2, "R5");

    xw(vaR, 0, 1, 32'h0002_8000, 32'h1111_1030, 0, 2, "R6");
    xw(vaR, 1, 1, 0, 32'h0, 1, 0, "R6");
    xw(vaR, 1, 0, 0, 32'h0, 1, 0, "R6");
    xw(vaS, 0, 1, 32'h0002_9000, 32'h0, 1, 2, "R6");
    xw(vaS, 0, 0, 0, 32'h2222_2040, 0, 0, "R12");
    xw(vaS, 1, 0, 0, 32'h2222_2040, 0, 0, "R6");
    xw(vaW, 1, 0, 32'h0002_A000, 32'h0, 1, 2, "R6");
    xw(vaW, 0, 1, 0, 32'h3333_3050, 0, 0, "R6");

    wbase(B1);
    xw(vaA, 0, 0, pt1, 32'hABCD_E345, 0, 2, "R9");
    wbase(B2);
    xw(vaA, 0, 0, 32'h0004_0000, 32'h5555_5345, 0, 2, "R9");

    wbase(B2);
    for (int i = 0; i < 8; i++)
      xw({10'(20 + i), 10'(i), 12'h0}, 0, 0, 32'h0006_0000 + i * 32'h1000,
         {20'h70000 + 20'(i), 12'h0}, 0, 2, "R8");
    xw({10'd20, 10'd0, 12'h0}, 0, 0, 0, 32'h7000_0000, 0, 0, "R8");
    xw({10'd28, 10'd8, 12'h0}, 0, 0, 32'h0006_8000, 32'h7000_8000, 0, 2, "R8");
    xw({10'd21, 10'd1, 12'h0}, 0, 0, 0, 32'h7000_1000, 0, 0, "R8");
    xw({10'd20, 10'd0, 12'h0}, 0, 0, 32'h0006_0000, 32'h7000_0000, 0, 2, "R8");
    xw({10'd22, 10'd2, 12'h0}, 0, 0, 0, 32'h7000_2000, 0, 0, "R8");
    xw({10'd21, 10'd1, 12'h0}, 0, 0, 32'h0006_1000, 32'h7000_1000, 0, 2, "R8");

    fork
      xw(vaQ, 0, 0, 32'h0008_0000, 32'h9999_9777, 0, 2, "R10");
      begin
        repeat (4) @(posedge clk);
        wbase(B2);
      end
    join
    xw(vaQ, 0, 0, 32'h0008_0000, 32'h9999_9777, 0, 2, "R10");

    repeat (5) @(negedge clk);
    chk(epa_q.size() == 0, "R4", "responses outstanding", epa_q.size(), 0);
    finish_run();
  end
endmodule